// File: doc/BRIEF.md
# Reload Timer with Shared Underflow Interrupt

This block is a down-counting timer that reloads itself from a software-written value each time it runs past zero. Every underflow raises a sticky flag. When the matching enable is on, the flag drives an interrupt request. The request line is shared with the overflow flag of a neighbouring free-running timer. A single acknowledge pulse from a DMA or I/O-service engine clears both pending flags together. Because of this, once the line is serviced by such an engine, the neighbouring source must keep its enable at 0 and be handled by polling.

Counting is driven by a three-state controller:
- **IDLE** is the state after reset. The counter is stopped and holds 0.
- The **START** transition goes from IDLE to **COUNT** on the first cycle with `count_en` high. On that edge the counter loads the reload value.
- **COUNT** decrements the counter on every enabled cycle.
- The **PAUSE** transition goes from COUNT to the **PAUSE** state when `count_en` drops. The count is held there.
- The **RESUME** transition goes from PAUSE back to COUNT when `count_en` returns. The count carries on from where it stopped, with no reload.

Software uses a small register port to reach the control/status word (address 0) and the reload word (address 1).

Top module: `reload_timer_irq`

## Requirements
- R1: After reset the count, the reload word, the underflow flag, the underflow enable and the shared overflow flag are all 0, the controller is in IDLE, and `irq` is low.
- R2: On the first enabled cycle after reset, the count loads the reload word without decrementing. Each later cycle with `count_en` high lowers the count by one. A cycle with `count_en` low leaves the count unchanged, and the next enabled cycle continues from the held value.
- R3: An enabled cycle in which the count is already 0 is an underflow. On that edge the count takes the reload word in place of wrapping to all ones, and the underflow flag becomes 1.
- R4: A write to address 0 copies data bit 3 into the underflow enable. If data bit 2 is 0, the write clears the underflow flag. If data bit 2 is 1, the write leaves the flag unchanged.
- R5: If an underflow and a software clear of the flag fall on the same edge, the flag ends up set.
- R6: `irq` is high exactly when (underflow flag and underflow enable) or (overflow flag and `ovf_ie`) holds.
- R7: A cycle with `ovf_pulse` high sets the shared overflow flag.
- R8: An `ack` pulse clears the underflow flag and the overflow flag on the same edge.
- R9: An underflow on the same edge as `ack` leaves the underflow flag set. An `ovf_pulse` on the same edge as `ack` leaves the overflow flag set.
- R10: A write to address 1 stores the full data word as the reload value. It does not change the running count; it takes effect at the next START or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_en | input | 1 | Counting enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control/status, 1 = reload |
| wr_data | input | CNT_W | Write data |
| ovf_pulse | input | 1 | Overflow event from the neighbouring timer |
| ovf_ie | input | 1 | Request enable of the neighbouring source |
| ack | input | 1 | Single-cycle service acknowledge |
| count_q | output | CNT_W | Current count |
| uf_flag | output | 1 | Underflow flag (status bit 2) |
| uf_ie | output | 1 | Underflow enable (status bit 3) |
| ovf_flag | output | 1 | Shared overflow flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with `CNT_W = 8`. This keeps the same flag and reload logic as the 16-bit default. It also lets a run with reload set to all ones wrap completely within a few hundred cycles, so the full-range period and the reload-of-zero case (an underflow on every enabled cycle) are both checked. The bench drives coincident edges on purpose: a clear landing on the underflow edge, an acknowledge landing on the underflow edge, and an overflow pulse landing on an acknowledge.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PAUSE = 2'd2
    } rtm_state_e;

    localparam logic ADDR_CTRL   = 1'b0;
    localparam logic ADDR_RELOAD = 1'b1;

endpackage

// File: rtl/rtm_counter.sv
module rtm_counter
    import rtm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q,
    output logic             uf_evt,
    output logic             running
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    rtm_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state: START, PAUSE, RESUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (count_en)  state_d = ST_COUNT;
            ST_COUNT: if (!count_en) state_d = ST_PAUSE;
            ST_PAUSE: if (count_en)  state_d = ST_COUNT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_comb begin
        count_d = count_q;
        uf_evt  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (count_en) count_d = reload_val;
            end
            ST_COUNT, ST_PAUSE: begin
                if (count_en) begin
                    if (count_q == ZERO) begin
                        count_d = reload_val;
                        uf_evt  = 1'b1;
                    end else begin
                        count_d = count_q - ONE;
                    end
                end
            end
            default: count_d = ZERO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= ZERO;
        else        count_q <= count_d;
    end

    assign running = (state_q != ST_IDLE);

endmodule

// File: rtl/rtm_status.sv
module rtm_status
    import rtm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int UF_BIT = 2,
    parameter int IE_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             uf_evt,
    input  logic             ack,
    output logic             uf_flag,
    output logic             uf_ie,
    output logic [CNT_W-1:0] reload_q
);

    logic ctrl_wr, reload_wr, sw_clear;

    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign reload_wr = wr_en && (wr_addr == ADDR_RELOAD);
    assign sw_clear  = ctrl_wr && !wr_data[UF_BIT];

    // hardware set outranks both clear sources
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                uf_flag <= 1'b0;
        else if (uf_evt)           uf_flag <= 1'b1;
        else if (ack || sw_clear)  uf_flag <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       uf_ie <= 1'b0;
        else if (ctrl_wr) uf_ie <= wr_data[IE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         reload_q <= '0;
        else if (reload_wr) reload_q <= wr_data;
    end

endmodule

// File: rtl/rtm_combiner.sv
module rtm_combiner (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_pulse,
    input  logic ack,
    input  logic uf_flag,
    input  logic uf_ie,
    input  logic ovf_ie,
    output logic ovf_flag,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovf_flag <= 1'b0;
        else if (ovf_pulse) ovf_flag <= 1'b1;
        else if (ack)       ovf_flag <= 1'b0;
    end

    assign irq = (uf_flag && uf_ie) || (ovf_flag && ovf_ie);

endmodule

// File: rtl/reload_timer_irq.sv
module reload_timer_irq #(
    parameter int CNT_W  = 16,
    parameter int UF_BIT = 2,
    parameter int IE_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ovf_pulse,
    input  logic             ovf_ie,
    input  logic             ack,
    output logic [CNT_W-1:0] count_q,
    output logic             uf_flag,
    output logic             uf_ie,
    output logic             ovf_flag,
    output logic             irq
);

    logic [CNT_W-1:0] reload_q;
    logic             uf_evt;
    logic             running;

    rtm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (count_en),
        .reload_val (reload_q),
        .count_q    (count_q),
        .uf_evt     (uf_evt),
        .running    (running)
    );

    rtm_status #(.CNT_W(CNT_W), .UF_BIT(UF_BIT), .IE_BIT(IE_BIT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .uf_evt   (uf_evt),
        .ack      (ack),
        .uf_flag  (uf_flag),
        .uf_ie    (uf_ie),
        .reload_q (reload_q)
    );

    rtm_combiner u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_pulse (ovf_pulse),
        .ack       (ack),
        .uf_flag   (uf_flag),
        .uf_ie     (uf_ie),
        .ovf_ie    (ovf_ie),
        .ovf_flag  (ovf_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/rtm_checker.sv
module rtm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             count_en,
    input logic             running,
    input logic             ack,
    input logic             ovf_pulse,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] reload_q,
    input logic             uf_flag,
    input logic             ovf_flag,
    input logic             irq
);

    logic at_uf;
    assign at_uf = running && count_en && (count_q == '0);

    // R3
    uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_uf |=> uf_flag);

    // R3
    reload_on_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_uf |=> (count_q == $past(reload_q)));

    // R2
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !count_en) |=> $stable(count_q));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !at_uf && !ovf_pulse) |=> (!uf_flag && !ovf_flag));

    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> ovf_flag);

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (uf_flag || ovf_flag));

endmodule

bind reload_timer_irq rtm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .running   (running),
    .ack       (ack),
    .ovf_pulse (ovf_pulse),
    .count_q   (count_q),
    .reload_q  (reload_q),
    .uf_flag   (uf_flag),
    .ovf_flag  (ovf_flag),
    .irq       (irq)
);

// File: tb/reload_timer_irq_tb.sv
module reload_timer_irq_tb;

    localparam int W       = 8;
    localparam int CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         count_en = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         ovf_pulse = 1'b0, ovf_ie = 1'b0, ack = 1'b0;
    logic [W-1:0] count_q;
    logic         uf_flag, uf_ie, ovf_flag, irq;

    always #(CLK_PER/2) clk = ~clk;

    reload_timer_irq #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ovf_pulse(ovf_pulse),
        .ovf_ie(ovf_ie), .ack(ack), .count_q(count_q), .uf_flag(uf_flag),
        .uf_ie(uf_ie), .ovf_flag(ovf_flag), .irq(irq)
    );

    typedef struct {
        logic [W-1:0] cnt;
        logic         uf, ie, ovf, irq;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;

    // reference state
    logic [W-1:0] m_cnt = '0, m_rel = '0;
    logic         m_run = 1'b0, m_uf = 1'b0, m_ie = 1'b0, m_ovf = 1'b0;

    task automatic step(input logic en, input logic we, input logic wa,
                        input logic [W-1:0] wd, input logic ovp,
                        input logic ak, input logic oie, input string tag);
        logic [W-1:0] nc;
        logic         ev, nuf, nie, novf;
        exp_t         e;
        @(negedge clk);
        count_en = en; wr_en = we; wr_addr = wa; wr_data = wd;
        ovf_pulse = ovp; ack = ak; ovf_ie = oie;
        nc = m_cnt; ev = 1'b0;
        if (en) begin
            if (!m_run)           nc = m_rel;
            else if (m_cnt == 0)  begin nc = m_rel; ev = 1'b1; end
            else                  nc = m_cnt - 1'b1;
        end
        nuf  = ev ? 1'b1 : ((ak || (we && !wa && !wd[2])) ? 1'b0 : m_uf);
        nie  = (we && !wa) ? wd[3] : m_ie;
        novf = ovp ? 1'b1 : (ak ? 1'b0 : m_ovf);
        if (we && wa) m_rel = wd;
        if (en) m_run = 1'b1;
        m_cnt = nc; m_uf = nuf; m_ie = nie; m_ovf = novf;
        e.cnt = nc; e.uf = nuf; e.ie = nie; e.ovf = novf;
        e.irq = (nuf & nie) | (novf & oie);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle_step(input logic en, input logic oie, input string tag);
        step(en, 1'b0, 1'b0, '0, 1'b0, 1'b0, oie, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (count_q !== e.cnt || uf_flag !== e.uf || uf_ie !== e.ie ||
                    ovf_flag !== e.ovf || irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: act cnt=%0h uf=%b ie=%b ovf=%b irq=%b exp cnt=%0h uf=%b ie=%b ovf=%b irq=%b",
                             e.tag, count_q, uf_flag, uf_ie, ovf_flag, irq,
                             e.cnt, e.uf, e.ie, e.ovf, e.irq);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PER * 100000);
        n_fail++;
        $display("FAIL watchdog: act running exp finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        n_chk++;
        if (count_q !== '0 || uf_flag || uf_ie || ovf_flag || irq) begin
            n_fail++;
            $display("FAIL R1: act cnt=%0h uf=%b ie=%b ovf=%b irq=%b exp all 0",
                     count_q, uf_flag, uf_ie, ovf_flag, irq);
        end
        idle_step(1'b0, 1'b0, "R1");

        // R10 reload write, R4 enable set
        step(0, 1, 1, 8'd5, 0, 0, 0, "R10");
        step(0, 1, 0, 8'h08, 0, 0, 0, "R4");
        // R2 start then decrement; R3 underflow reload; R6 irq
        for (int i = 0; i < 8; i++) idle_step(1'b1, 1'b0, "R2_R3_R6");
        // R2 hold while paused
        for (int i = 0; i < 3; i++) idle_step(1'b0, 1'b0, "R2");
        idle_step(1'b1, 1'b0, "R2");
        // R4 writing 1 to bit 2 keeps flag
        step(0, 1, 0, 8'h0C, 0, 0, 0, "R4");
        // R4 writing 0 clears
        step(0, 1, 0, 8'h08, 0, 0, 0, "R4");
        // R10 reload change mid-count
        step(1, 1, 1, 8'd2, 0, 0, 0, "R10");
        // R5 clear coincides with underflow
        for (int i = 0; i < 10; i++)
            step(1, (m_run && m_cnt == 0), 0, 8'h08, 0, 0, 0, "R5");
        // R7 overflow pulse, enable off
        step(0, 0, 0, '0, 1, 0, 0, "R7");
        idle_step(1'b0, 1'b0, "R7");
        // R8 ack clears both
        step(0, 0, 0, '0, 0, 1, 0, "R8");
        // R6 overflow-only request with underflow enable off
        step(0, 1, 0, 8'h00, 1, 0, 1, "R6");
        idle_step(1'b0, 1'b1, "R6");
        step(0, 0, 0, '0, 0, 1, 1, "R8");
        // R9 overflow pulse with ack
        step(0, 0, 0, '0, 1, 1, 1, "R9");
        step(0, 0, 0, '0, 0, 1, 0, "R8");
        // R9 underflow with ack
        step(0, 1, 0, 8'h08, 0, 0, 0, "R4");
        for (int i = 0; i < 8; i++)
            step(1, 0, 0, '0, 0, (m_run && m_cnt == 0), 0, "R9");
        // R3 reload of zero: underflow every cycle
        step(0, 1, 1, 8'd0, 0, 0, 0, "R10");
        for (int i = 0; i < 5; i++) idle_step(1'b1, 1'b0, "R3");
        step(1, 0, 0, '0, 0, 1, 0, "R9");
        // R3 full-range reload
        step(0, 1, 1, 8'hFF, 0, 0, 0, "R10");
        step(0, 1, 0, 8'h08, 0, 0, 0, "R4");
        for (int i = 0; i < 260; i++) idle_step(1'b1, 1'b0, "R3");

        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule